// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable model of a pipelined synchronous static memory whose data bus never needs an idle cycle when it turns between reads and writes. Every rising clock edge may accept a command: an address, a read/write choice, a load-or-advance choice, three chip selects and a per-byte write mask. The data transfer for that command happens in the cycle that follows. A write takes its data from the input bus at the end of that cycle. A read presents the stored word combinationally during that cycle. Because each command's data moves exactly one cycle later, a write can be followed at once by a read, including a read of the same word.

Each word is a parameterised number of bytes, four 9-bit bytes by default. Each byte has its own active-low write enable. A separate sequencer block steps a short burst, four beats by default, from a single loaded address. The burst order is either linear or interleaved, chosen by a static input. A clock-stall input freezes the whole block for as many cycles as needed. An asynchronous active-low output enable can force the bus driver off at any time. The bidirectional bus is modelled as separate input data, output data and output-enable signals.

Top module: `zbt_sram_model`

## Requirements
- R1: A command sampled with `stall` low, `advance` low and all three selects true (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) and `wr_n`=1 is a read. In the cycle after that edge, `dq_oe` is 1 (while `out_en_n` is 0) and `dq_out` equals the word stored at `addr`.
- R2: A load command with `wr_n`=0 is a write. At the next unstalled edge, every byte i whose `lane_wr_n[i]` was 0 at the command edge is written from `dq_in[9i+8:9i]`. Bytes with `lane_wr_n[i]`=1 keep their old value. A read issued on the very edge after the write command returns the new bytes.
- R3: An edge with `stall`=1 is ignored. No command is taken, no write is committed, and `dq_out` and `dq_oe` keep their values through the following cycle.
- R4: A load (`advance`=0) with any select false is a deselect. It starts no transfer, so `dq_oe` is 0 in the next cycle. A write issued on the edge before the deselect still commits its data.
- R5: `dq_oe` is 0 after reset, during the data cycle of any write, and in the cycle after a deselect.
- R6: `out_en_n`=1 forces `dq_oe` to 0 without waiting for a clock edge, and the read data on `dq_out` is left as it is. Lowering `out_en_n` during a read data cycle raises `dq_oe` at once.
- R7: With `ilv_order`=0, each edge with `advance`=1 during a live burst repeats the burst's operation type, whatever `wr_n` is. The operation goes to the next linear address: the low two address bits are (loaded low bits + beat) mod 4, the upper bits stay, and the sequence wraps.
- R8: With `ilv_order`=1, the burst address low bits are (loaded low bits XOR beat).
- R9: `lane_wr_n` is sampled again on every write burst beat and governs only that beat's bytes. During reads, `lane_wr_n` and `dq_in` change no stored word.
- R10: An edge with `advance`=1 when no burst is live (after reset or after a deselect) starts no transfer: `dq_oe` is 0 in the next cycle and `addr` is ignored.
- R11: Reads and writes may alternate on consecutive edges, with each read returning correct data in the cycle right after its command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, used on load commands |
| wr_n | input | 1 | 0 = write, 1 = read, on load commands |
| advance | input | 1 | 0 = load new command, 1 = advance burst |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| stall | input | 1 | 1 = ignore this clock edge entirely |
| lane_wr_n | input | NUM_BYTES | Per-byte write enables, active low |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | NUM_BYTES*BYTE_W | Write data, sampled at the end of the data cycle |
| dq_out | output | NUM_BYTES*BYTE_W | Read data, flow-through; zero outside read data cycles |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench aims at the read that immediately follows a write to the same word. A design that needed a bypass but lacked one would return stale data there. Stalled edges carry a conflicting write command, so a block that did not freeze would corrupt the word or drop the pending read data. Bursts are read back in both orders from an unaligned start, with `wr_n` low and a zero write mask on the read beats. A wrong wrap, wrong order, or a continuation that looked at `wr_n` would show up as wrong words or overwritten memory. A write followed by a deselect, and an advance with no live burst, expose a design that cancels pending transfers or drives the bus without a command.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic {
      OP_RD = 1'b0,
      OP_WR = 1'b1
   } op_e;

   // all three selects true: two active low, one active high
   function automatic logic chip_on(input logic a_n, input logic b, input logic c_n);
      return (!a_n) && b && (!c_n);
   endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
   parameter int ADDR_W    = 10,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ilv,
   output logic [ADDR_W-1:0] seq_addr
);

   localparam int CW = $clog2(BURST_LEN);

   logic [ADDR_W-1:0] base_q;
   logic [CW-1:0]     beat_q;
   logic [CW-1:0]     beat_nx;
   logic [CW-1:0]     lo_lin;
   logic [CW-1:0]     lo_ilv;
   logic [CW-1:0]     lo_sel;

   assign beat_nx = beat_q + 1'b1;
   assign lo_lin  = base_q[CW-1:0] + beat_nx;
   assign lo_ilv  = base_q[CW-1:0] ^ beat_nx;
   assign lo_sel  = ilv ? lo_ilv : lo_lin;

   generate
      if (ADDR_W > CW) begin : g_upper
         assign seq_addr = load ? ld_addr : {base_q[ADDR_W-1:CW], lo_sel};
      end else begin : g_flat
         assign seq_addr = load ? ld_addr : lo_sel;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         base_q <= ld_addr;
         beat_q <= '0;
      end else if (adv) begin
         beat_q <= beat_nx;
      end
   end

endmodule

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
   import zbt_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int NUM_BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stall,
   input  logic                 advance,
   input  logic                 wr_n,
   input  logic                 sel_a_n,
   input  logic                 sel_b,
   input  logic                 sel_c_n,
   input  logic [NUM_BYTES-1:0] lane_wr_n,
   input  logic [ADDR_W-1:0]    seq_addr,
   output logic                 do_load,
   output logic                 do_adv,
   output logic                 p_vld,
   output op_e                  p_op,
   output logic [ADDR_W-1:0]    p_addr,
   output logic [NUM_BYTES-1:0] p_lane_n
);

   logic sel;
   logic live_q;
   op_e  burst_op_q;
   op_e  new_op;

   assign sel     = chip_on(sel_a_n, sel_b, sel_c_n);
   assign new_op  = wr_n ? OP_RD : OP_WR;
   assign do_load = !stall && !advance && sel;
   assign do_adv  = !stall && advance && live_q;

   // burst state: set by a load, cleared by a deselect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q     <= 1'b0;
         burst_op_q <= OP_RD;
      end else if (!stall && !advance) begin
         live_q <= sel;
         if (sel) burst_op_q <= new_op;
      end
   end

   // data-phase stage: what moves on the bus in the next cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_vld    <= 1'b0;
         p_op     <= OP_RD;
         p_addr   <= '0;
         p_lane_n <= '1;
      end else if (!stall) begin
         p_vld    <= do_load || do_adv;
         p_op     <= do_load ? new_op : burst_op_q;
         p_addr   <= seq_addr;
         p_lane_n <= lane_wr_n;
      end
   end

endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
   parameter int ADDR_W    = 10,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 4
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [NUM_BYTES-1:0]        wr_lane,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [NUM_BYTES*BYTE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
         logic [BYTE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g])
               mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
         end

         assign rd_data[g*BYTE_W +: BYTE_W] = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/zbt_sram_model.sv
module zbt_sram_model
   import zbt_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int BYTE_W    = 9,
   parameter int NUM_BYTES = 4,
   parameter int BURST_LEN = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic                        wr_n,
   input  logic                        advance,
   input  logic                        sel_a_n,
   input  logic                        sel_b,
   input  logic                        sel_c_n,
   input  logic                        stall,
   input  logic [NUM_BYTES-1:0]        lane_wr_n,
   input  logic                        ilv_order,
   input  logic                        out_en_n,
   input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
   output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
   output logic                        dq_oe
);

   localparam int DATA_W = NUM_BYTES * BYTE_W;

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("BURST_LEN must be a power of two, at least 2");
      end
      if (ADDR_W < $clog2(BURST_LEN) || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must cover one burst and stay at most 16");
      end
      if (BYTE_W < 1 || NUM_BYTES < 1) begin : g_bad_word
         $error("BYTE_W and NUM_BYTES must be positive");
      end
   endgenerate

   logic                 do_load;
   logic                 do_adv;
   logic [ADDR_W-1:0]    seq_addr;
   logic                 p_vld;
   op_e                  p_op;
   logic [ADDR_W-1:0]    p_addr;
   logic [NUM_BYTES-1:0] p_lane_n;
   logic                 commit;
   logic                 rd_phase;
   logic [DATA_W-1:0]    rd_data;

   zbt_burst_seq #(
      .ADDR_W   (ADDR_W),
      .BURST_LEN(BURST_LEN)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (do_load),
      .adv     (do_adv),
      .ld_addr (addr),
      .ilv     (ilv_order),
      .seq_addr(seq_addr)
   );

   zbt_cmd_ctrl #(
      .ADDR_W   (ADDR_W),
      .NUM_BYTES(NUM_BYTES)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall    (stall),
      .advance  (advance),
      .wr_n     (wr_n),
      .sel_a_n  (sel_a_n),
      .sel_b    (sel_b),
      .sel_c_n  (sel_c_n),
      .lane_wr_n(lane_wr_n),
      .seq_addr (seq_addr),
      .do_load  (do_load),
      .do_adv   (do_adv),
      .p_vld    (p_vld),
      .p_op     (p_op),
      .p_addr   (p_addr),
      .p_lane_n (p_lane_n)
   );

   assign commit   = !stall && p_vld && (p_op == OP_WR);
   assign rd_phase = p_vld && (p_op == OP_RD);

   zbt_byte_array #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .NUM_BYTES(NUM_BYTES)
   ) array_i (
      .clk    (clk),
      .wr_en  (commit),
      .wr_lane(~p_lane_n),
      .wr_addr(p_addr),
      .wr_data(dq_in),
      .rd_addr(p_addr),
      .rd_data(rd_data)
   );

   assign dq_out = rd_phase ? rd_data : '0;
   assign dq_oe  = rd_phase && !out_en_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
   import zbt_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall,
   input logic              advance,
   input logic              wr_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              out_en_n,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   logic sel;
   logic live_q;

   assign sel = chip_on(sel_a_n, sel_b, sel_c_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else if (!stall && !advance) live_q <= sel;
   end

   // R1
   read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !advance && sel && wr_n) |=> (dq_oe || out_en_n));

   // R3
   stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(dq_out));

   // R4
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !advance && !sel) |=> !dq_oe);

   // R5
   write_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !advance && sel && !wr_n) |=> !dq_oe);

   // R6
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !dq_oe);

   // R10
   idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && advance && !live_q) |=> !dq_oe);

endmodule

bind zbt_sram_model zbt_sram_chk #(
   .DATA_W(NUM_BYTES * BYTE_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .stall   (stall),
   .advance (advance),
   .wr_n    (wr_n),
   .sel_a_n (sel_a_n),
   .sel_b   (sel_b),
   .sel_c_n (sel_c_n),
   .out_en_n(out_en_n),
   .dq_out  (dq_out),
   .dq_oe   (dq_oe)
);

// File: tb/zbt_sram_model_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_model_tb_top;

   localparam logic [2:0] CE_ON    = 3'b010;  // {sel_a_n, sel_b, sel_c_n}
   localparam logic [2:0] CE_OFF_A = 3'b110;
   localparam logic [2:0] CE_OFF_B = 3'b000;
   localparam logic [2:0] CE_OFF_C = 3'b011;
   localparam logic [35:0] ONES    = 36'hFFFFFFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        wr_n = 1'b1;
   logic        advance = 1'b0;
   logic        sel_a_n = 1'b1;
   logic        sel_b = 1'b0;
   logic        sel_c_n = 1'b1;
   logic        stall = 1'b0;
   logic [3:0]  lane_wr_n = 4'hF;
   logic        ilv_order = 1'b0;
   logic        out_en_n = 1'b0;
   logic [35:0] dq_in = '0;
   logic [35:0] dq_out;
   logic        dq_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic        cap_oe;
   logic [35:0] cap_dq;

   always #5 clk = ~clk;

   zbt_sram_model dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n), .advance(advance),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .stall(stall),
      .lane_wr_n(lane_wr_n), .ilv_order(ilv_order), .out_en_n(out_en_n),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                         input logic [3:0] be_n);
      logic [35:0] r = old_w;
      for (int i = 0; i < 4; i++)
         if (!be_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
      return r;
   endfunction

   task automatic chk_oe(input string tag, input logic exp);
      total++;
      if (cap_oe !== exp) begin
         bad++;
         $display("FAIL %s dq_oe actual=%0b expected=%0b", tag, cap_oe, exp);
      end
   endtask

   task automatic chk_dq(input string tag, input logic [35:0] exp);
      total++;
      if (cap_dq !== exp) begin
         bad++;
         $display("FAIL %s dq_out actual=%h expected=%h", tag, cap_dq, exp);
      end
   endtask

   // sample outputs of the current cycle, then drive the next edge's inputs
   task automatic issue(input logic st, input logic adv, input logic [2:0] ce, input logic rd,
                        input logic [9:0] a, input logic [3:0] be, input logic [35:0] din);
      @(negedge clk);
      cap_oe = dq_oe;
      cap_dq = dq_out;
      stall = st; advance = adv; {sel_a_n, sel_b, sel_c_n} = ce;
      wr_n = rd; addr = a; lane_wr_n = be; dq_in = din;
   endtask

   task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [35:0] din);
      issue(1'b0, 1'b0, CE_ON, 1'b0, a, be, din);
   endtask
   task automatic rdc(input logic [9:0] a, input logic [35:0] din);
      issue(1'b0, 1'b0, CE_ON, 1'b1, a, 4'hF, din);
   endtask
   task automatic advc(input logic [3:0] be, input logic [35:0] din);
      issue(1'b0, 1'b1, CE_ON, 1'b0, 10'h3FF, be, din);
   endtask
   task automatic dsel(input logic [35:0] din);
      issue(1'b0, 1'b0, CE_OFF_B, 1'b1, 10'h000, 4'hF, din);
   endtask

   task automatic read_word(input logic [9:0] a, input logic [35:0] exp, input string tag);
      rdc(a, '0);
      dsel('0);
      chk_oe(tag, 1'b1);
      chk_dq(tag, exp);
   endtask

   localparam logic [35:0] D5  = 36'h123456789;
   localparam logic [35:0] E10 = 36'h0A0B0C0D1;
   localparam logic [35:0] E11 = 36'h9876FEDC1;
   localparam logic [35:0] E12 = 36'h3C3C3C3C3;
   localparam logic [35:0] W20 = 36'h5A5A5A5A5;
   localparam logic [35:0] B0  = 36'h100000011;
   localparam logic [35:0] B1  = 36'h200000022;
   localparam logic [35:0] B2  = 36'h300000033;
   localparam logic [35:0] B3  = 36'h400000044;
   localparam logic [35:0] A0  = 36'h0C0FFEE00;
   localparam logic [35:0] A1  = 36'h0C0FFEE01;
   localparam logic [35:0] A2  = 36'h0C0FFEE02;
   localparam logic [35:0] A3  = 36'h0C0FFEE03;

   task automatic t_reset();
      dsel('0);
      chk_oe("R5 reset", 1'b0);
      advc(4'h0, '0);
      dsel('0);
      chk_oe("R10 advance after reset", 1'b0);
   endtask

   task automatic t_raw();
      wr(10'd5, 4'h0, '0);
      rdc(10'd5, D5);
      chk_oe("R5 write data cycle", 1'b0);
      dsel('0);
      chk_oe("R1 read drives", 1'b1);
      chk_dq("R2 read after write", D5);
   endtask

   task automatic t_bytes();
      wr(10'd6, 4'h0, '0);
      wr(10'd6, 4'b1010, 36'hAAAAAAAAA);
      rdc(10'd6, 36'h555555555);
      dsel('0);
      chk_dq("R2 byte mask", merge(36'hAAAAAAAAA, 36'h555555555, 4'b1010));
   endtask

   task automatic t_alt();
      wr(10'd10, 4'h0, '0);
      rdc(10'd5, E10);
      wr(10'd11, 4'h0, '0);
      chk_oe("R11 read5 oe", 1'b1);
      chk_dq("R11 read5", D5);
      rdc(10'd10, E11);
      chk_oe("R11 write11 cycle", 1'b0);
      wr(10'd12, 4'h0, '0);
      chk_dq("R11 read10", E10);
      rdc(10'd11, E12);
      chk_oe("R11 write12 cycle", 1'b0);
      dsel('0);
      chk_dq("R11 read11", E11);
      read_word(10'd12, E12, "R11 read12");
   endtask

   task automatic t_stall();
      rdc(10'd5, '0);
      issue(1'b1, 1'b0, CE_ON, 1'b0, 10'd5, 4'h0, ONES);
      chk_dq("R3 before stall", D5);
      issue(1'b1, 1'b0, CE_ON, 1'b0, 10'd5, 4'h0, ONES);
      chk_oe("R3 stalled oe", 1'b1);
      chk_dq("R3 stalled data", D5);
      dsel(ONES);
      chk_oe("R3 second stall oe", 1'b1);
      chk_dq("R3 second stall data", D5);
      dsel('0);
      chk_oe("R3 resume", 1'b0);
      read_word(10'd5, D5, "R3 no write while stalled");
   endtask

   task automatic t_desel();
      wr(10'd20, 4'h0, '0);
      issue(1'b0, 1'b0, CE_OFF_C, 1'b1, 10'd20, 4'hF, W20);
      rdc(10'd20, '0);
      chk_oe("R4 deselect cycle", 1'b0);
      dsel('0);
      chk_dq("R4 pending write kept", W20);
   endtask

   task automatic t_oe();
      rdc(10'd5, '0);
      out_en_n = 1'b1;
      dsel('0);
      chk_oe("R6 oe_n high", 1'b0);
      chk_dq("R6 data kept", D5);
      out_en_n = 1'b0;
      #1;
      cap_oe = dq_oe;
      chk_oe("R6 oe_n low async", 1'b1);
      out_en_n = 1'b1;
      #1;
      cap_oe = dq_oe;
      chk_oe("R6 oe_n high async", 1'b0);
      out_en_n = 1'b0;
   endtask

   task automatic t_lin();
      ilv_order = 1'b0;
      wr(10'h032, 4'h0, '0);
      advc(4'h0, B0);
      advc(4'h0, B1);
      advc(4'h0, B2);
      dsel(B3);
      // read burst from 0x31 with wr_n low and full mask: must stay a read
      rdc(10'h031, '0);
      advc(4'h0, ONES);
      chk_dq("R7 beat0 0x31", B3);
      advc(4'h0, ONES);
      chk_dq("R7 beat1 0x32", B0);
      advc(4'h0, ONES);
      chk_dq("R7 beat2 0x33", B1);
      dsel(ONES);
      chk_oe("R7 beat3 oe", 1'b1);
      chk_dq("R7 beat3 wrap 0x30", B2);
   endtask

   task automatic t_ilv();
      ilv_order = 1'b1;
      rdc(10'h031, '0);
      advc(4'h0, ONES);
      chk_dq("R8 beat0 0x31", B3);
      advc(4'h0, ONES);
      chk_dq("R8 beat1 0x30", B2);
      advc(4'h0, ONES);
      chk_dq("R8 beat2 0x33", B1);
      dsel(ONES);
      chk_dq("R8 beat3 0x32", B0);
      ilv_order = 1'b0;
      read_word(10'h032, B0, "R9 read ignores mask");
   endtask

   task automatic t_bw_burst();
      wr(10'h040, 4'h0, '0);
      advc(4'h0, A0);
      advc(4'h0, A1);
      advc(4'h0, A2);
      dsel(A3);
      wr(10'h040, 4'b1110, '0);
      advc(4'b0111, ONES);
      advc(4'b1111, ONES);
      advc(4'b1111, ONES);
      dsel(ONES);
      read_word(10'h040, merge(A0, ONES, 4'b1110), "R9 beat0 byte0");
      read_word(10'h041, merge(A1, ONES, 4'b0111), "R9 beat1 byte3");
      read_word(10'h042, A2, "R9 beat2 none");
      read_word(10'h043, A3, "R9 beat3 none");
   endtask

   task automatic t_idle_adv();
      rdc(10'd5, '0);
      issue(1'b0, 1'b0, CE_OFF_A, 1'b1, 10'd5, 4'hF, '0);
      advc(4'h0, '0);
      chk_oe("R4 deselect ends burst", 1'b0);
      dsel('0);
      chk_oe("R10 advance after deselect", 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_raw();
      t_bytes();
      t_alt();
      t_stall();
      t_desel();
      t_oe();
      t_lin();
      t_ilv();
      t_bw_burst();
      t_idle_adv();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule